// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital control core of a 12-bit successive-approximation converter with a parallel result bus. All control inputs are sampled on one fast system clock: an active-low select (`sel_n`), a convert-strobe level (`cvt`), an active-low read (`rd_n`), a byte-fold select, an active-low nap enable and an active-low power-down/reset line. Edges on `sel_n` and `cvt` open a sampling window or start a conversion, depending on the level of the other signal. During a conversion the block resolves one result bit per clock from a single-bit comparator input, most significant bit first, and then latches the result for readout.

The state machine has six states. ST_IDLE waits. ST_ACQ is the sampling window. ST_CONV runs the bit search while `busy` is high. ST_NAP is a low-power wait. ST_RESET is the filtered reset phase. ST_PDOWN is power-down. The transitions are:
- ST_IDLE/ST_NAP to ST_ACQ on a sampling start.
- ST_IDLE to ST_NAP while nap is enabled, and ST_NAP back to ST_IDLE once it is released.
- ST_ACQ to ST_CONV on a conversion edge once the minimum window has passed.
- ST_CONV to ST_IDLE on an abort or on completion.
- ST_CONV to ST_ACQ on completion with `sel_n` low and `cvt` high (back-to-back).
- ST_CONV to ST_NAP on completion with nap enabled.
- Any state to ST_RESET once the reset line has been low long enough.
- ST_RESET to ST_PDOWN after a longer low time.
- ST_RESET/ST_PDOWN to ST_IDLE when the line returns high.

An abort or a reset leaves the marker code 1111_1110_0000 in the result register. The first four conversions after any reset are flagged as not valid. All delays are cycle counts set by parameters.

Top module: `sarconv_ctrl`

## Requirements
- R1: A conversion starts only from ST_ACQ. It is triggered by `cvt` falling while `sel_n` is low, or by `sel_n` falling while `cvt` is low. If the minimum window has already passed, `busy` is high in the cycle after the edge is sampled. Otherwise the request is held until the window has passed.
- R2: Sampling (`sampling` high) starts in one of three ways. The first is `cvt` rising with `sel_n` low while not busy. The second is `sel_n` falling with `cvt` high while not busy. The third is at the end of a conversion when `sel_n` is low and `cvt` is high; in that case `sampling` is high in the same cycle that `busy` falls. `cvt` rising while `sel_n` is high does not start sampling.
- R3: `busy` stays high for exactly W+1 cycles. In the k-th busy cycle (k = 1..W), `cmp_in` decides result bit W-k: 1 keeps the trial bit and 0 clears it. The result is latched in the same cycle that `busy` falls.
- R4: `sel_n` falling while `busy` and `cvt` are both high aborts the conversion. On the next cycle `busy` is low, the result is 12'hFE0 and `data_valid` is low.
- R5: `dq_en` is high exactly when `sel_n` and `rd_n` are both low, in the same cycle. While `dq_en` is low, `dq` is all zeros.
- R6: With `byte_sel` low, `dq` carries result bits 11..0. With `byte_sel` high, `dq[11:8]` carries result bits 3..0 and `dq[7:0]` is zero.
- R7: After a two-flop synchroniser, a low on `pdr_n` lasting fewer than RST_CYC cycles has no effect. A low of RST_CYC cycles or more stops any conversion (`busy` low) and sets the result to 12'hFE0.
- R8: If `pdr_n` stays low for PD_CYC cycles after synchronisation, `pwr_dn` goes high. `pwr_dn` returns low within a few cycles of `pdr_n` rising.
- R9: `data_valid` is low after any reset. It stays low through the first four completed conversions and goes high with the completion of the fifth.
- R10: With `nap_en_n` low, `napping` is high in the same cycle that `busy` falls, unless back-to-back sampling applies. It stays high until sampling starts or `nap_en_n` goes high.
- R11: When the conversion edge arrives early, `sampling` stays high for exactly ACQ_CYC cycles. For the first window after ST_NAP, it stays high for exactly ACQ_CYC+NAP_XTRA cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low system reset |
| sel_n | input | 1 | active-low select |
| cvt | input | 1 | convert-strobe level |
| rd_n | input | 1 | active-low read |
| byte_sel | input | 1 | fold low nibble onto upper lines |
| nap_en_n | input | 1 | active-low nap enable |
| pdr_n | input | 1 | asynchronous active-low power-down/reset |
| cmp_in | input | 1 | comparator decision for the current trial |
| busy | output | 1 | conversion in progress |
| sampling | output | 1 | sampling window active |
| napping | output | 1 | nap state active |
| pwr_dn | output | 1 | power-down state active |
| data_valid | output | 1 | latched result follows the initial invalid run |
| dq_en | output | 1 | pad drive enable for `dq` (tri-state control) |
| dq | output | W | result bus |

## Verification
The bench builds the block with W=12, ACQ_CYC=3, NAP_XTRA=4, RST_CYC=3, PD_CYC=24 and INVALID_N=4. The short acquisition and nap extension keep the exact window lengths countable in a handful of cycles. With PD_CYC=24, the bench can reach the power-down state and then compare the filtered reset against a sub-threshold glitch within one short run. Twelve bits with INVALID_N=4 let all-zero, all-one and mixed codes, the byte fold and the fifth-conversion valid edge be seen together.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV,
        ST_NAP,
        ST_RESET,
        ST_PDOWN
    } sarc_state_t;
endpackage

// File: rtl/sarc_rstfilt.sv
module sarc_rstfilt #(
    parameter int RST_CYC = 3,
    parameter int PD_CYC  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdr_n,
    output logic rst_hold,
    output logic pdn_hold
);
    localparam int CW = $clog2(PD_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;

    // two-flop synchroniser, then a saturating low-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            low_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], pdr_n};
            if (sync_q[1])
                low_cnt <= '0;
            else if (low_cnt != CW'(PD_CYC))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rst_hold = !sync_q[1] && (low_cnt >= CW'(RST_CYC));
    assign pdn_hold = !sync_q[1] && (low_cnt == CW'(PD_CYC));

    // R8: power-down is only reached through the reset phase
    p_pdn_follows_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdn_hold) |-> $past(rst_hold));
endmodule

// File: rtl/sarc_sar.sv
module sarc_sar #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         cmp,
    output logic         done,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] trial;
    logic [W-1:0] mask;
    logic         run;
    logic [W-1:0] kept;

    always_comb kept = cmp ? trial : (trial & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial <= '0;
            mask  <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
            code  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                run <= 1'b0;
            end else if (start) begin
                trial <= TOP_BIT;
                mask  <= TOP_BIT;
                run   <= 1'b1;
            end else if (run) begin
                if (mask[0]) begin
                    code <= kept;
                    done <= 1'b1;
                    run  <= 1'b0;
                end else begin
                    trial <= kept | (mask >> 1);
                    mask  <= mask >> 1;
                end
            end
        end
    end

    // R3: a finished search always follows its start by W+1 edges
    p_sar_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, W + 1));
endmodule

// File: rtl/sarc_fsm.sv
module sarc_fsm
    import sarc_pkg::*;
#(
    parameter int W         = 12,
    parameter int ACQ_CYC   = 3,
    parameter int NAP_XTRA  = 4,
    parameter int INVALID_N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         cvt,
    input  logic         nap_en_n,
    input  logic         rst_hold,
    input  logic         pdn_hold,
    input  logic         sar_done,
    input  logic [W-1:0] sar_code,
    output logic         busy,
    output logic         sampling,
    output logic         napping,
    output logic         pwr_dn,
    output logic         data_valid,
    output logic [W-1:0] result,
    output logic         sar_start,
    output logic         sar_abort
);
    localparam logic [W-1:0] MARK = {7'h7F, {(W-7){1'b0}}};
    localparam int AW = $clog2(ACQ_CYC + NAP_XTRA + 1) + 1;
    localparam int VW = $clog2(INVALID_N + 2);

    sarc_state_t state, nxt;

    logic          sel_q, cvt_q;
    logic [AW-1:0] acq_cnt;
    logic          ext_acq, pend;
    logic [VW-1:0] vcnt;
    logic          good;

    logic sel_fall, cvt_fall, cvt_rise;
    logic samp_go, conv_go, abort_go, acq_ok;

    always_comb begin
        sel_fall = sel_q & ~sel_n;
        cvt_fall = cvt_q & ~cvt;
        cvt_rise = ~cvt_q & cvt;
        samp_go  = (cvt_rise & ~sel_n) | (sel_fall & cvt);
        conv_go  = (cvt_fall & ~sel_n) | (sel_fall & ~cvt);
        abort_go = (state == ST_CONV) & sel_fall & cvt;
        acq_ok   = acq_cnt >= (ext_acq ? AW'(ACQ_CYC + NAP_XTRA) : AW'(ACQ_CYC));
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (pdn_hold) begin
            nxt = ST_PDOWN;
        end else if (rst_hold) begin
            nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (samp_go)        nxt = ST_ACQ;
                    else if (!nap_en_n) nxt = ST_NAP;
                end
                ST_NAP: begin
                    if (samp_go)       nxt = ST_ACQ;
                    else if (nap_en_n) nxt = ST_IDLE;
                end
                ST_ACQ: begin
                    if ((conv_go || pend) && acq_ok) nxt = ST_CONV;
                end
                ST_CONV: begin
                    if (abort_go)                 nxt = ST_IDLE;
                    else if (sar_done) begin
                        if (!sel_n && cvt)        nxt = ST_ACQ;
                        else if (!nap_en_n)       nxt = ST_NAP;
                        else                      nxt = ST_IDLE;
                    end
                end
                ST_RESET: nxt = ST_IDLE;
                ST_PDOWN: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // edge history, acquisition window and result bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b1;
            cvt_q   <= 1'b0;
            acq_cnt <= '0;
            ext_acq <= 1'b0;
            pend    <= 1'b0;
            result  <= MARK;
            vcnt    <= '0;
            good    <= 1'b0;
        end else begin
            sel_q <= sel_n;
            cvt_q <= cvt;
            if (nxt == ST_ACQ && state != ST_ACQ) begin
                acq_cnt <= AW'(1);
                ext_acq <= (state == ST_NAP);
                pend    <= 1'b0;
            end else if (state == ST_ACQ) begin
                if (!acq_ok) acq_cnt <= acq_cnt + 1'b1;
                pend <= pend | conv_go;
            end
            if (rst_hold) begin
                result <= MARK;
                vcnt   <= '0;
                good   <= 1'b0;
            end else if (abort_go) begin
                result <= MARK;
                good   <= 1'b0;
            end else if (state == ST_CONV && sar_done) begin
                result <= sar_code;
                if (vcnt != VW'(INVALID_N + 1)) vcnt <= vcnt + 1'b1;
                good   <= (vcnt >= VW'(INVALID_N));
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state == ST_CONV);
        sampling   = (state == ST_ACQ);
        napping    = (state == ST_NAP);
        pwr_dn     = (state == ST_PDOWN);
        data_valid = good;
        sar_start  = (state == ST_ACQ) && (nxt == ST_CONV);
        sar_abort  = (state == ST_CONV) && (abort_go || rst_hold);
    end

    // R1: every conversion is entered from the sampling window
    p_start_from_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sampling));

    // R4: an abort leaves the marker and drops busy
    p_abort_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_go && !rst_hold) |=> (result == MARK && !busy && !data_valid));

    // R9: a reset phase always clears the valid flag
    p_reset_clears_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold |=> !data_valid);

    // R10: nap is only entered while nap is enabled
    p_nap_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(napping) |-> $past(!nap_en_n));
endmodule

// File: rtl/sarc_bus.sv
module sarc_bus #(
    parameter int W = 12
) (
    input  logic         sel_n,
    input  logic         rd_n,
    input  logic         byte_sel,
    input  logic [W-1:0] result,
    output logic         dq_en,
    output logic [W-1:0] dq
);
    localparam int LOW_W = W - 4;

    always_comb begin
        dq_en = ~sel_n & ~rd_n;
        if (!dq_en)
            dq = '0;
        else if (byte_sel)
            dq = {result[3:0], {LOW_W{1'b0}}};
        else
            dq = result;
    end
endmodule

// File: rtl/sarconv_ctrl.sv
module sarconv_ctrl #(
    parameter int W         = 12,
    parameter int ACQ_CYC   = 3,
    parameter int NAP_XTRA  = 4,
    parameter int RST_CYC   = 3,
    parameter int PD_CYC    = 40,
    parameter int INVALID_N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         cvt,
    input  logic         rd_n,
    input  logic         byte_sel,
    input  logic         nap_en_n,
    input  logic         pdr_n,
    input  logic         cmp_in,
    output logic         busy,
    output logic         sampling,
    output logic         napping,
    output logic         pwr_dn,
    output logic         data_valid,
    output logic         dq_en,
    output logic [W-1:0] dq
);
    logic         rst_hold, pdn_hold;
    logic         sar_start, sar_abort, sar_done;
    logic [W-1:0] sar_code, result;

    sarc_rstfilt #(.RST_CYC(RST_CYC), .PD_CYC(PD_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .pdr_n(pdr_n),
        .rst_hold(rst_hold), .pdn_hold(pdn_hold)
    );

    sarc_sar #(.W(W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(sar_start), .abort(sar_abort),
        .cmp(cmp_in), .done(sar_done), .code(sar_code)
    );

    sarc_fsm #(.W(W), .ACQ_CYC(ACQ_CYC), .NAP_XTRA(NAP_XTRA),
               .INVALID_N(INVALID_N)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cvt(cvt),
        .nap_en_n(nap_en_n), .rst_hold(rst_hold), .pdn_hold(pdn_hold),
        .sar_done(sar_done), .sar_code(sar_code),
        .busy(busy), .sampling(sampling), .napping(napping),
        .pwr_dn(pwr_dn), .data_valid(data_valid), .result(result),
        .sar_start(sar_start), .sar_abort(sar_abort)
    );

    sarc_bus #(.W(W)) u_bus (
        .sel_n(sel_n), .rd_n(rd_n), .byte_sel(byte_sel),
        .result(result), .dq_en(dq_en), .dq(dq)
    );
endmodule

// File: tb/sim_sarconv_ctrl.sv
module sim_sarconv_ctrl;
    localparam int CLK_PER   = 10;
    localparam int W         = 12;
    localparam int ACQ_CYC   = 3;
    localparam int NAP_XTRA  = 4;
    localparam int RST_CYC   = 3;
    localparam int PD_CYC    = 24;
    localparam int INVALID_N = 4;
    localparam logic [W-1:0] MARK = 12'hFE0;

    logic clk = 1'b0;
    logic rst_n, sel_n, cvt, rd_n, byte_sel, nap_en_n, pdr_n, cmp_in;
    logic busy, sampling, napping, pwr_dn, data_valid, dq_en;
    logic [W-1:0] dq;

    always #(CLK_PER/2) clk = ~clk;

    sarconv_ctrl #(.W(W), .ACQ_CYC(ACQ_CYC), .NAP_XTRA(NAP_XTRA),
                   .RST_CYC(RST_CYC), .PD_CYC(PD_CYC), .INVALID_N(INVALID_N)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cvt(cvt), .rd_n(rd_n),
        .byte_sel(byte_sel), .nap_en_n(nap_en_n), .pdr_n(pdr_n), .cmp_in(cmp_in),
        .busy(busy), .sampling(sampling), .napping(napping), .pwr_dn(pwr_dn),
        .data_valid(data_valid), .dq_en(dq_en), .dq(dq)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    logic [W-1:0] cur_val = '0;
    logic [W-1:0] expq[$];
    bit skip_next = 0;
    bit busy_d = 0;
    int bidx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // comparator model: bit k of the analog value, MSB first, one per busy cycle
    always @(negedge clk) begin
        if (busy) begin
            if (bidx < W) cmp_in = cur_val[W-1-bidx];
            bidx++;
        end else begin
            bidx = 0;
        end
    end

    // scoreboard monitor: compares each finished conversion with the queue (R3)
    always @(negedge clk) begin
        if (busy_d && !busy) begin
            if (skip_next) begin
                skip_next = 0;
            end else if (expq.size() == 0) begin
                chk(0, "R3 unexpected completion", 1, 0);
            end else begin
                logic [W-1:0] e;
                e = expq.pop_front();
                if (dq_en && !byte_sel) chk(dq == e, "R3 result", dq, e);
            end
        end
        busy_d = busy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sampling via cvt rise, immediate conversion request via cvt fall
    task automatic conv_fast(input logic [W-1:0] v, output int acq, output int blen);
        cur_val = v;
        expq.push_back(v);
        @(negedge clk) cvt = 1'b1;
        @(negedge clk) cvt = 1'b0;
        acq = 0;
        while (!busy) begin
            if (sampling) acq++;
            @(negedge clk);
        end
        blen = 0;
        while (busy) begin
            blen++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int acq, blen;
        logic [W-1:0] vals [5] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h3C7};
        rst_n = 0; sel_n = 1; cvt = 0; rd_n = 1; byte_sel = 0;
        nap_en_n = 1; pdr_n = 1; cmp_in = 0;
        tick(4);
        rst_n = 1;
        tick(2);
        // reset state (R5, R9)
        chk(!busy && !sampling && !napping && !pwr_dn, "R2 reset state idle", busy, 0);
        chk(!data_valid, "R9 valid low after reset", data_valid, 0);
        chk(!dq_en && dq == '0, "R5 bus off after reset", dq_en, 0);

        sel_n = 0; rd_n = 0;
        tick(2);
        chk(dq_en, "R5 enable with sel and rd low", dq_en, 1);

        // five conversions: lengths, values, valid edge (R3, R9, R11, R2)
        for (int i = 0; i < 5; i++) begin
            conv_fast(vals[i], acq, blen);
            if (i == 0) chk(acq == ACQ_CYC, "R11 normal window length", acq, ACQ_CYC);
            chk(blen == W + 1, "R3 busy length", blen, W + 1);
            chk(data_valid == (i == INVALID_N), "R9 valid after fifth", data_valid, (i == INVALID_N));
        end
        chk(dq == 12'h3C7, "R3 latched value readout", dq, 12'h3C7);

        // bus gating and byte fold (R5, R6)
        rd_n = 1; tick(1);
        chk(!dq_en && dq == '0, "R5 rd high disables", dq, 0);
        rd_n = 0; sel_n = 1; tick(1);
        chk(!dq_en && dq == '0, "R5 sel high disables", dq, 0);
        sel_n = 0; byte_sel = 1; tick(1);
        chk(dq == 12'h700, "R6 byte fold", dq, 12'h700);
        byte_sel = 0; tick(1);
        chk(dq == 12'h3C7, "R6 full word", dq, 12'h3C7);

        // sampling by sel fall with cvt high, conversion by sel fall with cvt low (R1, R2)
        cur_val = 12'h5A3;
        sel_n = 1; tick(1);
        cvt = 1; tick(3);
        chk(!sampling, "R2 cvt rise with sel high ignored", sampling, 0);
        sel_n = 0; tick(1);
        chk(sampling, "R2 sel fall with cvt high samples", sampling, 1);
        sel_n = 1; tick(1);
        cvt = 0; tick(ACQ_CYC + 1);
        chk(sampling && !busy, "R1 cvt fall with sel high no start", busy, 0);
        expq.push_back(12'h5A3);
        sel_n = 0; tick(1);
        chk(busy, "R1 sel fall with cvt low starts", busy, 1);
        while (busy) @(negedge clk);

        // back-to-back: sampling at conversion end (R2)
        cur_val = 12'h1E9;
        expq.push_back(12'h1E9);
        @(negedge clk) cvt = 1;
        @(negedge clk) cvt = 0;
        while (!busy) @(negedge clk);
        tick(3);
        cvt = 1;
        while (busy) @(negedge clk);
        chk(sampling, "R2 back-to-back sampling at end", sampling, 1);
        cur_val = 12'hC36;
        expq.push_back(12'hC36);
        cvt = 0;
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);

        // abort (R4)
        cur_val = 12'h777;
        @(negedge clk) cvt = 1;
        @(negedge clk) cvt = 0;
        while (!busy) @(negedge clk);
        tick(4);
        cvt = 1; tick(1);
        sel_n = 1; tick(1);
        skip_next = 1;
        sel_n = 0; tick(1);
        chk(!busy, "R4 abort drops busy", busy, 0);
        chk(dq == MARK, "R4 abort marker", dq, MARK);
        chk(!data_valid, "R4 abort clears valid", data_valid, 0);
        cvt = 0; tick(2);
        conv_fast(12'h456, acq, blen);
        chk(data_valid, "R9 valid again after abort", data_valid, 1);

        // nap and extended window (R10, R11)
        nap_en_n = 0; tick(2);
        chk(napping, "R10 nap from idle", napping, 1);
        conv_fast(12'h9B2, acq, blen);
        chk(acq == ACQ_CYC + NAP_XTRA, "R11 window after nap", acq, ACQ_CYC + NAP_XTRA);
        chk(napping, "R10 nap right after busy falls", napping, 1);
        nap_en_n = 1; tick(2);
        chk(!napping, "R10 nap left when disabled", napping, 1);

        // short reset glitch ignored (R7)
        cur_val = 12'h2D4;
        expq.push_back(12'h2D4);
        @(negedge clk) cvt = 1;
        @(negedge clk) cvt = 0;
        while (!busy) @(negedge clk);
        pdr_n = 0; tick(RST_CYC - 1);
        pdr_n = 1;
        blen = 0;
        while (busy) begin blen++; @(negedge clk); end
        chk(data_valid, "R7 short glitch ignored", data_valid, 1);

        // long reset during conversion (R7, R9)
        @(negedge clk) cvt = 1;
        @(negedge clk) cvt = 0;
        while (!busy) @(negedge clk);
        skip_next = 1;
        pdr_n = 0; tick(RST_CYC + 4);
        chk(!busy, "R7 reset stops conversion", busy, 0);
        chk(dq == MARK, "R7 reset marker", dq, MARK);
        chk(!pwr_dn, "R8 not yet powered down", pwr_dn, 0);
        pdr_n = 1; tick(5);
        for (int i = 0; i < 5; i++) begin
            conv_fast(vals[4 - i], acq, blen);
            chk(data_valid == (i == INVALID_N), "R9 valid after reset run", data_valid, (i == INVALID_N));
        end

        // power-down (R8)
        pdr_n = 0; tick(PD_CYC + 8);
        chk(pwr_dn, "R8 powered down", pwr_dn, 1);
        chk(!busy && dq == MARK, "R8 marker in powerdown", dq, MARK);
        pdr_n = 1; tick(5);
        chk(!pwr_dn, "R8 wake on release", pwr_dn, 0);
        conv_fast(12'h0F1, acq, blen);
        chk(!data_valid, "R9 invalid after powerdown", data_valid, 0);
        tick(3);
        finish_run();
    end
endmodule